// File: doc/BRIEF.md
# GPIO Pad Controller with Interrupts

This block manages a bank of general-purpose pads behind a 32-bit register bus. Every pad owns a 16-byte slot holding two configuration words and a value word. The value word sets the pad direction through two enables, each active low, and holds the output level. When the output is disabled, reading the value word returns the synchronized input level.

Each pad can raise an event on a rising edge, a falling edge, either edge, a high level or a low level. Three trigger bits in the first configuration word choose the mode. Captured events collect in status words that hold 32 pads each and clear when a 1 is written to a bit. A registered OR of all status bits drives one interrupt line.

Software sets up the pads, enables triggers on the pads it cares about, and services the interrupt. It reads the status words and writes back the bits it has handled.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: Pad p owns byte offsets 16*p to 16*p+15. In that slot, 0x0 is the primary configuration word, 0x4 is the secondary configuration word and 0x8 is the value word. Offset 0xC reads as zero and ignores writes.
- R2: The primary configuration word keeps only these fields: bit 31 (open drain), bit 27 (direct interrupt), bits 26:24 (triggers), bits 10:9 (pull strength), bits 8:7 (pull direction) and bits 2:0 (function select). Every other bit reads 0, so a write of 0xFFFFFFFF reads back 0x8F000787. The secondary configuration word keeps all 32 bits.
- R3: After reset, all configuration words are 0, value bits 2:1 read 11, all status bits are 0, the interrupt line is 0 and every pad_oe bit is 0.
- R4: Value bit 1 is the output enable and bit 2 is the input enable; both are active low. pad_oe is the inverse of bit 1 and pad_out follows bit 0. A read of bit 0 returns the stored level when bit 1 is 0. When bit 1 is 1, it returns the input after a two-flop synchronizer, so a change on the pad shows two clock edges later.
- R5: The trigger bits sit at 24 (level), 25 (positive) and 26 (negative). With bit 24 clear, bit 25 alone catches rising edges, bit 26 alone catches falling edges, and both catch either edge. The status bit sets on the third clock edge after the pad input changes.
- R6: With bit 24 set, bit 25 selects active-high level and bit 26 selects active-low level. While the pad stays at the active level, setting wins over a clear, so the status bit still reads 1 after a clear write.
- R7: A status bit never sets when all three trigger bits are 0, when the function select is nonzero, or when the input enable (value bit 2) is 1.
- R8: The status for pad p is bit p mod 32 of the word at 0x800 + 4*(p/32). Writing a 1 clears that bit and writing a 0 leaves it unchanged.
- R9: irq is a registered OR of all status bits. It rises on the clock edge after a status bit sets and falls on the clock edge after the last status bit clears.
- R10: These accesses read as zero and change no state: slots of pads at or above NPADS, status words beyond the last one used, and addresses that are not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NPADS | Raw pad input levels |
| pad_out | output | NPADS | Output level per pad |
| pad_oe | output | NPADS | Output driver enable per pad, active high |
| irq | output | 1 | Combined interrupt |

## Verification
Corrupted configuration or value state shows at the ports at once: bus_rdata reads it back directly, and pad_oe or pad_out change on the same cycle. A fault in the synchronizer, edge or level logic shows on the status word at a fixed cycle after the stimulus. The bench samples the edge before that cycle and the edge on it, so an extra or missing flop is caught. A wrong interrupt register shows on irq exactly one edge after the status changes. Gating faults show as status bits that set when the rules forbid it.

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int NPADS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPADS-1:0] pad_in,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] pad_oe,
  output logic             irq
);
  localparam int NW = (NPADS + 31) / 32;
  localparam int PW = $clog2(NPADS);
  localparam int SW = NW * 32;
  localparam logic [31:0] CFG_MASK = 32'h8F00_0787;

  logic [31:0] cfg_a [NPADS];
  logic [31:0] cfg_b [NPADS];
  logic [2:0]  valw  [NPADS];
  logic [NPADS-1:0] s1, s2, s3, ev;
  logic [SW-1:0] stat, clr, evx;

  wire [6:0]    pidx = bus_addr[10:4];
  wire [1:0]    wsel = bus_addr[3:2];
  wire [8:0]    sidx = bus_addr[10:2];
  wire [PW-1:0] pi   = pidx[PW-1:0];
  wire aligned = (bus_addr[1:0] == 2'b00);
  wire pad_hit = aligned && !bus_addr[11] && (32'(pidx) < NPADS);
  wire st_hit  = aligned &&  bus_addr[11] && (32'(sidx) < NW);

  always_comb begin
    for (int i = 0; i < NPADS; i++) begin
      ev[i] = (cfg_a[i][2:0] == 3'd0) && !valw[i][2] &&
              (cfg_a[i][24] ? ((cfg_a[i][25] & s2[i]) | (cfg_a[i][26] & ~s2[i]))
                            : ((cfg_a[i][25] & s2[i] & ~s3[i]) | (cfg_a[i][26] & ~s2[i] & s3[i])));
    end
    evx = '0;
    evx[NPADS-1:0] = ev;
    clr = '0;
    if (bus_wr && st_hit)
      for (int w = 0; w < NW; w++)
        if (32'(sidx) == w) clr[w*32 +: 32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPADS; i++) begin
        cfg_a[i] <= '0;
        cfg_b[i] <= '0;
        valw[i]  <= 3'b110;
      end
      s1 <= '0; s2 <= '0; s3 <= '0;
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      s1 <= pad_in; s2 <= s1; s3 <= s2;
      stat <= (stat & ~clr) | evx;
      irq  <= |stat;
      if (bus_wr && pad_hit) begin
        case (wsel)
          2'd0: cfg_a[pi] <= bus_wdata & CFG_MASK;
          2'd1: cfg_b[pi] <= bus_wdata;
          2'd2: valw[pi]  <= bus_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (pad_hit) begin
      case (wsel)
        2'd0: bus_rdata = cfg_a[pi];
        2'd1: bus_rdata = cfg_b[pi];
        2'd2: bus_rdata = {29'd0, valw[pi][2:1], valw[pi][1] ? s2[pi] : valw[pi][0]};
        default: bus_rdata = '0;
      endcase
    end else if (st_hit) begin
      for (int w = 0; w < NW; w++)
        if (32'(sidx) == w) bus_rdata = stat[w*32 +: 32];
    end
  end

  for (genvar g = 0; g < NPADS; g++) begin : g_pad
    assign pad_oe[g]  = ~valw[g][1];
    assign pad_out[g] = valw[g][0];

    AST_GATED_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[g]) |-> $past((cfg_a[g][2:0] == 3'd0) && !valw[g][2] && (|cfg_a[g][26:24]))); // R7
    AST_CLEAR_BY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat[g]) |-> $past(bus_wr && bus_addr[11])); // R8
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat) |=> irq); // R9
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|stat) |=> !irq); // R9
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(pad_oe)); // R4
endmodule

// File: tb/gpio_pad_ctrl_bench.sv
module gpio_pad_ctrl_bench;
  localparam int NPADS = 40;
  logic clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, r;
  logic [NPADS-1:0] pad_in = '0, pad_out, pad_oe;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  gpio_pad_ctrl #(.NPADS(NPADS)) u_gpio_pad_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // {neg,pos,lvl, start, end, expected}
  localparam logic [5:0] VEC [9] = '{
    6'b010_0_1_1, 6'b010_1_0_0, 6'b100_1_0_1, 6'b100_0_1_0, 6'b110_0_1_1,
    6'b110_1_0_1, 6'b011_0_1_1, 6'b101_1_0_1, 6'b000_0_1_0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(4);
    @(negedge clk) rst_n = 1;
    cyc(1);
    rd(12'h000, r); chk("R3 conf reset", r, 0);
    rd(12'h008, r); chk("R3 value reset", r, 32'h6);
    rd(12'h800, r); chk("R3 status reset", r, 0);
    chk("R3 irq reset", {31'd0, irq}, 0);
    chk("R3 pad_oe reset", {24'd0, pad_oe[7:0]}, 0);

    wr(12'h050, 32'hFFFFFFFF); rd(12'h050, r); chk("R2 conf mask", r, 32'h8F000787);
    wr(12'h054, 32'hA5A51234); rd(12'h054, r); chk("R2 conf2 full", r, 32'hA5A51234);
    wr(12'h05C, 32'h12345678); rd(12'h05C, r); chk("R1 debug word zero", r, 0);
    wr(12'h274, 32'h0000BEEF); rd(12'h274, r); chk("R1 last pad slot", r, 32'h0000BEEF);
    rd(12'h264, r); chk("R1 neighbour slot untouched", r, 0);
    wr(12'h050, 0);

    wr(12'h028, 32'h1);
    chk("R4 oe on", {31'd0, pad_oe[2]}, 1);
    chk("R4 out level", {31'd0, pad_out[2]}, 1);
    rd(12'h028, r); chk("R4 read stored level", r, 32'h1);
    wr(12'h028, 32'h0); chk("R4 out low", {31'd0, pad_out[2]}, 0);
    wr(12'h028, 32'h3);
    chk("R4 oe off", {31'd0, pad_oe[2]}, 0);
    @(negedge clk) pad_in[2] = 1;
    cyc(1); rd(12'h028, r); chk("R4 sync not yet", r, 32'h2);
    cyc(1); rd(12'h028, r); chk("R4 sync input", r, 32'h3);

    for (int v = 0; v < 9; v++) begin
      string tag;
      tag = VEC[v][3] ? "R6" : (VEC[v][5:3] == 3'b000 ? "R7" : "R5");
      wr(12'h030, 0);
      wr(12'h038, 32'h2);
      @(negedge clk) pad_in[3] = VEC[v][2];
      cyc(4);
      wr(12'h030, {5'd0, VEC[v][5:3], 24'd0});
      cyc(2);
      wr(12'h800, 32'hFFFFFFFF);
      cyc(2);
      rd(12'h800, r); chk({tag, " idle"}, r, 0);
      @(negedge clk) pad_in[3] = VEC[v][1];
      cyc(2); rd(12'h800, r); chk({tag, " not before third edge"}, r, 0);
      cyc(1); rd(12'h800, r); chk({tag, " event"}, r, {28'd0, VEC[v][0], 3'd0});
      cyc(1); chk("R9 irq one edge later", {31'd0, irq}, {31'd0, VEC[v][0]});
      wr(12'h030, 0);
      wr(12'h800, 32'hFFFFFFFF);
      cyc(2);
    end

    // R6: level persists across a clear
    wr(12'h030, 32'h03000000);
    @(negedge clk) pad_in[3] = 1;
    cyc(4);
    wr(12'h800, 32'h8); rd(12'h800, r); chk("R6 level resets after clear", r, 32'h8);
    @(negedge clk) pad_in[3] = 0;
    cyc(4);
    wr(12'h800, 32'h8); rd(12'h800, r); chk("R6 clears once level gone", r, 0);
    chk("R9 irq still high", {31'd0, irq}, 1);
    cyc(1); chk("R9 irq falls", {31'd0, irq}, 0);

    // R7: function select nonzero, input disabled
    wr(12'h030, 32'h02000001);
    @(negedge clk) pad_in[3] = 1;
    cyc(5); rd(12'h800, r); chk("R7 mux blocks", r, 0);
    @(negedge clk) pad_in[3] = 0;
    wr(12'h030, 32'h02000000); wr(12'h038, 32'h6);
    @(negedge clk) pad_in[3] = 1;
    cyc(5); rd(12'h800, r); chk("R7 input disable blocks", r, 0);

    // R8: second status word
    wr(12'h238, 32'h2); wr(12'h230, 32'h02000000);
    cyc(3);
    @(negedge clk) pad_in[35] = 1;
    cyc(4);
    rd(12'h804, r); chk("R8 word1 bit3", r, 32'h8);
    rd(12'h800, r); chk("R8 word0 clean", r, 0);
    wr(12'h804, 32'h0); rd(12'h804, r); chk("R8 zero write no effect", r, 32'h8);
    wr(12'h804, 32'h8); rd(12'h804, r); chk("R8 w1c", r, 0);

    // R10: unmapped accesses
    wr(12'h280, 32'hFFFFFFFF); rd(12'h280, r); chk("R10 pad beyond range", r, 0);
    rd(12'h000, r); chk("R10 no alias write", r, 0);
    wr(12'h808, 32'hFFFFFFFF); rd(12'h808, r); chk("R10 status beyond range", r, 0);
    wr(12'h276, 32'h1); rd(12'h274, r); chk("R10 misaligned write ignored", r, 32'h0000BEEF);
    rd(12'h276, r); chk("R10 misaligned read zero", r, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule